// File: doc/BRIEF.md
# Masked-Write GPIO Output Bank

This block is a 32-pin general-purpose I/O bank on a simple register bus. A single address selects both the register that a write goes to and the word that the combinational read port returns. The bank holds three registers: pin direction, output enable and output data. It also returns the pin levels, after a two-flop synchronizer.

Output data is never written as a whole word. Two write-only update registers each cover one half of the pins. In a word written to either of them, the upper 16 bits are a per-bit protect mask and the lower 16 bits are the new values. Software can therefore set or clear any group of pins in one bus write, without a read-modify-write and without disturbing pins that other software owns. The pads are modelled as three separate vectors: drive value, drive enable and sampled input.

The bus has no valid/ready handshake. Every cycle with the write strobe high is one accepted write. Reads have no back-pressure and return data in the same cycle as the address.

Top module: `gpio_mask_bank`

## Requirements
- R1: After reset, the direction, output-enable and output-data registers are all zero, so `pad_oe` and `pad_out` are zero and both read back as zero.
- R2: A write to offset 0x000 updates output bits 15..0. Each bit whose mask bit (write data bit 16+k) is 0 takes write data bit k. Each bit whose mask bit is 1 keeps its value.
- R3: A write to offset 0x004 updates output bits 31..16 with the same masking: data bit k and mask bit 16+k control pin 16+k. Output bits 15..0 are unchanged by this write.
- R4: A masked-update write whose mask half is all ones leaves every output data bit unchanged.
- R5: The direction register (offset 0x204, 1 = output) and the output-enable register (offset 0x208) are full 32-bit read/write registers. A write is visible on a read in the next cycle.
- R6: `pad_oe[n]` is 1 only when both direction bit n and output-enable bit n are 1. `pad_out` always carries the output data register.
- R7: A read of offset 0x060 returns the pin levels, bit n for pin n. A change on `pad_in` shows there after exactly two rising clock edges.
- R8: Reads of 0x000, 0x004 and of any undefined offset return 0. Writes to 0x060 or to an undefined offset change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte offset of the register accessed |
| bus_we | input | 1 | Write strobe; one write per cycle while high |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, same cycle |
| pad_in | input | 32 | Raw pin levels from the pads |
| pad_out | output | 32 | Drive value for each pin |
| pad_oe | output | 32 | Drive enable for each pin, 1 = drive |

## Verification
Assertions check three things on every cycle. A masked update loads exactly the unmasked bits and holds the masked ones. A half-word update never reaches the other half. A cycle without a write leaves all registers stable. The assertions also check that the pin-level read lags the pads by two cycles, that drive enable never exceeds the direction bits, and that write-only offsets read as zero. Only the bench scenarios show the actual stored values after a sequence of mixed-mask writes. They also show that protected halves survive all-ones masks, that writes to the read-only and unused offsets have no effect, and that the reset values are correct.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned HALF_W = 16;
  localparam int unsigned PIN_W  = 2 * HALF_W;
  localparam int unsigned ADDR_W = 12;

  // Offsets are part of the software contract and stay fixed.
  localparam logic [ADDR_W-1:0] OFS_UPD_LO = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_UPD_HI = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_LEVEL  = 12'h060;
  localparam logic [ADDR_W-1:0] OFS_DIR    = 12'h204;
  localparam logic [ADDR_W-1:0] OFS_DRVEN  = 12'h208;

  typedef struct packed {
    logic upd_lo;
    logic upd_hi;
    logic dir;
    logic drven;
  } wr_sel_t;
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] chain_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= '0;
        else if (s == 0) chain_q[s] <= pin_i;
        else chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];

  // Warm-up counter so the latency check never looks past reset.
  logic [1:0] warm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warm_q <= '0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end

  generate
    if (STAGES == 2) begin : g_chk
      p_sync_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q >= 2'd2) |-> (sync_o == $past(pin_i, 2)))
        else $error("R7: synchronizer latency is not two cycles");
    end
  endgenerate
endmodule

// File: rtl/gpio_out_regs.sv
module gpio_out_regs
  import gpio_bank_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  wr_sel_t          sel,
  input  logic [PIN_W-1:0] wdata,
  output logic [PIN_W-1:0] dir_q,
  output logic [PIN_W-1:0] drven_q,
  output logic [PIN_W-1:0] val_q
);
  logic [HALF_W-1:0] prot, fresh;
  assign prot  = wdata[PIN_W-1:HALF_W];
  assign fresh = wdata[HALF_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '0;
      drven_q <= '0;
    end else begin
      if (sel.dir)   dir_q   <= wdata;
      if (sel.drven) drven_q <= drven_q ^ (drven_q ^ wdata);
    end
  end

  // One masked-update slice per half; slice h answers to its own strobe.
  genvar h;
  generate
    for (h = 0; h < 2; h++) begin : g_half
      logic hit;
      assign hit = (h == 0) ? sel.upd_lo : sel.upd_hi;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) val_q[h*HALF_W +: HALF_W] <= '0;
        else if (hit)
          val_q[h*HALF_W +: HALF_W] <= (prot & val_q[h*HALF_W +: HALF_W]) | (~prot & fresh);
      end
    end
  endgenerate

  p_lo_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sel.upd_lo |=> ((val_q[HALF_W-1:0] & ~$past(prot)) == ($past(fresh) & ~$past(prot))))
    else $error("R2: unmasked low bits not loaded");
  p_lo_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sel.upd_lo |=> ((val_q[HALF_W-1:0] & $past(prot)) == ($past(val_q[HALF_W-1:0]) & $past(prot))))
    else $error("R4: masked low bits changed");
  p_hi_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sel.upd_hi |=> ((val_q[PIN_W-1:HALF_W] & ~$past(prot)) == ($past(fresh) & ~$past(prot))))
    else $error("R3: unmasked high bits not loaded");
  p_hi_isolated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sel.upd_hi |=> $stable(val_q[HALF_W-1:0]))
    else $error("R3: high update disturbed low half");
  p_idle_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == '0) |=> ($stable(val_q) && $stable(dir_q) && $stable(drven_q)))
    else $error("R8: register changed without a decoded write");
endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
  import gpio_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [PIN_W-1:0]  level,
  input  logic [PIN_W-1:0]  dir,
  input  logic [PIN_W-1:0]  drven,
  output logic [PIN_W-1:0]  rdata
);
  always_comb begin
    unique case (addr)
      OFS_LEVEL: rdata = level;
      OFS_DIR:   rdata = dir;
      OFS_DRVEN: rdata = drven;
      default:   rdata = '0;
    endcase
  end

  p_wo_reads_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((addr == OFS_UPD_LO) || (addr == OFS_UPD_HI)) |-> (rdata == '0))
    else $error("R8: write-only offset returned data");
endmodule

// File: rtl/gpio_mask_bank.sv
module gpio_mask_bank
  import gpio_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [PIN_W-1:0]  bus_wdata,
  output logic [PIN_W-1:0]  bus_rdata,
  input  logic [PIN_W-1:0]  pad_in,
  output logic [PIN_W-1:0]  pad_out,
  output logic [PIN_W-1:0]  pad_oe
);
  wr_sel_t          sel;
  logic [PIN_W-1:0] dir_q, drven_q, val_q, level;

  always_comb begin
    sel        = '0;
    sel.upd_lo = bus_we && (bus_addr == OFS_UPD_LO);
    sel.upd_hi = bus_we && (bus_addr == OFS_UPD_HI);
    sel.dir    = bus_we && (bus_addr == OFS_DIR);
    sel.drven  = bus_we && (bus_addr == OFS_DRVEN);
  end

  gpio_out_regs u_regs (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wdata(bus_wdata),
    .dir_q(dir_q), .drven_q(drven_q), .val_q(val_q)
  );

  gpio_pin_sync #(.WIDTH(PIN_W), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(pad_in), .sync_o(level)
  );

  gpio_read_mux u_rd (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .level(level),
    .dir(dir_q), .drven(drven_q), .rdata(bus_rdata)
  );

  assign pad_out = val_q;
  assign pad_oe  = dir_q & drven_q;

  p_drive_needs_dir_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == OFS_DIR) |-> ((pad_oe & ~bus_rdata) == '0))
    else $error("R6: pin driven without direction bit");
  p_drive_needs_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == OFS_DRVEN) |-> ((pad_oe & ~bus_rdata) == '0))
    else $error("R6: pin driven without enable bit");
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pad_oe == '0 && pad_out == '0))
    else $error("R1: outputs not cleared by reset");
endmodule

// File: tb/gpio_mask_bank_test.sv
module gpio_mask_bank_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata, pad_out, pad_oe;
  logic [31:0] pad_in = '0;

  always #10 clk = ~clk; // 50 MHz

  gpio_mask_bank uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  typedef struct {
    int          kind; // 0 read data, 1 pad_out, 2 pad_oe
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t exp_q[$];
  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  // Monitor: pops one expectation per cycle, 5 ns after the falling edge.
  always begin
    @(negedge clk);
    #5;
    if (exp_q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it  = exp_q.pop_front();
      act = (it.kind == 0) ? bus_rdata : (it.kind == 1) ? pad_out : pad_oe;
      n_checks++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic expect_item(input int kind, input logic [11:0] a,
                             input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk);
    bus_addr = a;
    it.kind = kind; it.exp = e; it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    expect_item(0, 12'h204, 32'h0, "R1 dir after reset");
    expect_item(0, 12'h208, 32'h0, "R1 enable after reset");
    expect_item(1, 12'h000, 32'h0, "R1 pad_out after reset");
    expect_item(2, 12'h000, 32'h0, "R1 pad_oe after reset");
    // R2 unmasked and partly masked low updates
    bus_write(12'h000, 32'h0000_A5C3);
    expect_item(1, 12'h100, 32'h0000_A5C3, "R2 full low load");
    bus_write(12'h000, 32'hFF00_0011);
    expect_item(1, 12'h100, 32'h0000_A511, "R2 masked low load");
    // R3 high half
    bus_write(12'h004, 32'h0000_1234);
    expect_item(1, 12'h100, 32'h1234_A511, "R3 full high load");
    bus_write(12'h004, 32'h0F0F_FFFF);
    expect_item(1, 12'h100, 32'hF2F4_A511, "R3 masked high load");
    // R4 all-ones mask
    bus_write(12'h000, 32'hFFFF_0000);
    bus_write(12'h004, 32'hFFFF_FFFF);
    expect_item(1, 12'h100, 32'hF2F4_A511, "R4 all-ones mask");
    // R5 and R6
    bus_write(12'h204, 32'hFFFF_00FF);
    bus_write(12'h208, 32'h0F0F_0F0F);
    expect_item(0, 12'h204, 32'hFFFF_00FF, "R5 dir readback");
    expect_item(0, 12'h208, 32'h0F0F_0F0F, "R5 enable readback");
    expect_item(2, 12'h100, 32'h0F0F_000F, "R6 drive enable gating");
    expect_item(1, 12'h100, 32'hF2F4_A511, "R6 pad_out carries data");
    // R8 zero reads and ignored writes
    expect_item(0, 12'h000, 32'h0, "R8 low update reads zero");
    expect_item(0, 12'h004, 32'h0, "R8 high update reads zero");
    expect_item(0, 12'h100, 32'h0, "R8 undefined reads zero");
    bus_write(12'h060, 32'hFFFF_FFFF);
    bus_write(12'h300, 32'h0000_0000);
    expect_item(0, 12'h204, 32'hFFFF_00FF, "R8 dir untouched");
    expect_item(0, 12'h208, 32'h0F0F_0F0F, "R8 enable untouched");
    expect_item(1, 12'h100, 32'hF2F4_A511, "R8 data untouched");
    // R7 two-edge latency, two patterns
    expect_item(0, 12'h060, 32'h0, "R7 level idle");
    @(negedge clk);
    pad_in = 32'hDEAD_BEEF;
    begin
      item_t it;
      it.kind = 0; it.exp = 32'h0; it.tag = "R7 zero edges";
      bus_addr = 12'h060;
      exp_q.push_back(it);
    end
    expect_item(0, 12'h060, 32'h0, "R7 one edge");
    expect_item(0, 12'h060, 32'hDEAD_BEEF, "R7 two edges");
    pad_in = 32'h1357_9BDF;
    expect_item(0, 12'h060, 32'hDEAD_BEEF, "R7 second pattern one edge");
    expect_item(0, 12'h060, 32'h1357_9BDF, "R7 second pattern two edges");
    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule